// File: doc/BRIEF.md
# Programmable Deglitch Filter and Edge Pulse Generator

This block conditions one asynchronous logic input against a free-running clock. The input first crosses a two-flop synchronizer. A qualification timer then accepts a new level only after the synchronized input has held that level for a selectable number of clock ticks. Shorter excursions are dropped, and any return to the old level restarts the timer. The filtered level then drives an output stage. That stage either passes the level through or emits a pulse of fixed width on the chosen edges. A final polarity bit can invert the result.

All timing is counted in clock ticks. The parameter `TICKS_PER_UNIT` sets the base step, and the four width settings are one to four times that step. Configuration inputs are plain levels that are sampled on every clock edge, so a change acts on the next edge.

The filter is a two-state machine. FLT_HOLD means the input matches the filtered level. FLT_QUAL means a candidate level is being timed. Its transitions are T_START (HOLD to QUAL, a mismatch begins), T_ACCEPT (QUAL or HOLD to HOLD, the count reaches the threshold and the filtered level flips) and T_ABORT (QUAL to HOLD, the input returns before the threshold). The pulse generator has two states, PG_IDLE and PG_PULSE. Its transitions are T_FIRE (IDLE to PULSE on a qualifying edge), T_REFIRE (PULSE to PULSE on a new edge, which restarts the width count) and T_EXPIRE (PULSE to IDLE once the width has elapsed).

Top module: `deglitch_edge_top`

## Requirements
- R1: A qualified level change on `sig_in`, applied before clock edge k, appears on `sig_out` (level mode, no inversion) right after edge k+W+3, where W is the selected width in ticks. Three of those cycles are fixed latency: synchronizer, filter register and output register.
- R2: `width_sel` values 0, 1, 2 and 3 select W = 1, 2, 3 and 4 times `TICKS_PER_UNIT` ticks.
- R3: If the input holds a new level for only W-1 ticks, it is discarded and the output does not change.
- R4: If the input holds a new level for exactly W ticks, it is accepted. In level mode the output pulse lasts as many cycles as the input pulse.
- R5: Any return of the synchronized input to the filtered level restarts the qualification count from zero.
- R6: `mode_sel` encoding: 0 = pulse on rising filtered edges, 1 = pulse on falling filtered edges, 2 = pulse on both edges, 3 = output follows the filtered level.
- R7: In the three pulse modes, each pulse is active for exactly W cycles. A new qualifying edge during a pulse restarts the W-cycle count, so the two pulses merge.
- R8: `invert` = 1 inverts the output after mode selection.
- R9: During and right after synchronous reset, `sig_out` equals the inactive level `invert`. The filtered state loads the synchronized input, so reset itself never produces an edge.
- R10: Configuration changes act at the next clock edge. When the width is reduced mid-count, the running count is compared against the new threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous input to be conditioned |
| width_sel | input | 2 | Filter and pulse width select, W = (width_sel+1)*TICKS_PER_UNIT |
| mode_sel | input | 2 | Output mode: 0 rise, 1 fall, 2 both, 3 level |
| invert | input | 1 | Output polarity; 1 inverts |
| sig_out | output | 1 | Registered conditioned output |

## Verification
For every width setting and every mode, the bench applies pulses of W-1 ticks and of exactly W ticks. This separates rejection from acceptance at the boundary, and it measures the start time, active length and number of output pulses, which shows the mode decoding and the fixed latency. A long pulse in both-edge mode shows two separate pulses, while a W-tick pulse in that mode shows a merged, retriggered pulse. Separate patterns cover these remaining cases: a broken pulse made of two W-1 halves (timer restart), a width reduction mid-count (new threshold), inversion in level and pulse modes, and an input held high through reset (no spurious edge).

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

    typedef enum logic [1:0] {
        MODE_RISE  = 2'd0,
        MODE_FALL  = 2'd1,
        MODE_BOTH  = 2'd2,
        MODE_LEVEL = 2'd3
    } out_mode_e;

    typedef enum logic {
        FLT_HOLD = 1'b0,
        FLT_QUAL = 1'b1
    } flt_state_e;

    typedef enum logic {
        PG_IDLE  = 1'b0,
        PG_PULSE = 1'b1
    } pg_state_e;

endpackage

// File: rtl/deglitch_sync.sv
module deglitch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) chain_q[s] <= async_i;
            end else begin : g_next
                always_ff @(posedge clk) chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/deglitch_filter.sv
module deglitch_filter
    import deglitch_pkg::*;
#(
    parameter int CW        = 4,
    parameter int MAX_TICKS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_i,
    input  logic [CW-1:0] thr_i,
    output logic          filt_o
);
    flt_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          filt_q, filt_n;
    logic          differ;
    logic          reached;

    assign differ  = (sync_i != filt_q);
    assign reached = (({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, thr_i});

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            filt_q  <= sync_i;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            filt_q  <= filt_n;
        end
    end

    // Next state and datapath
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        filt_n  = filt_q;
        unique case (state_q)
            FLT_HOLD: begin
                cnt_n = '0;
                if (differ) begin
                    if (reached) begin
                        filt_n = sync_i;                // T_ACCEPT
                    end else begin
                        state_n = FLT_QUAL;             // T_START
                        cnt_n   = {{(CW-1){1'b0}}, 1'b1};
                    end
                end
            end
            FLT_QUAL: begin
                if (!differ) begin
                    state_n = FLT_HOLD;                 // T_ABORT
                    cnt_n   = '0;
                end else if (reached) begin
                    state_n = FLT_HOLD;                 // T_ACCEPT
                    cnt_n   = '0;
                    filt_n  = sync_i;
                end else begin
                    cnt_n = cnt_q + {{(CW-1){1'b0}}, 1'b1};
                end
            end
            default: begin
                state_n = FLT_HOLD;
                cnt_n   = '0;
            end
        endcase
    end

    // Output process
    always_comb filt_o = filt_q;

    AST_FLIP_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_i))); // R4

    AST_FLIP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && filt_q != $past(filt_q)) |->
        (({1'b0, $past(cnt_q)} + 1) >= {1'b0, $past(thr_i)})); // R3

    AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == FLT_QUAL && $past(sync_i) == $past(filt_q)) |->
        (cnt_q == '0 && state_q == FLT_HOLD)); // R5

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < MAX_TICKS); // R10

endmodule

// File: rtl/deglitch_edge.sv
module deglitch_edge
    import deglitch_pkg::*;
#(
    parameter int CW        = 4,
    parameter int MAX_TICKS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_i,
    input  logic          filt_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] thr_i,
    output logic          pre_o
);
    pg_state_e     state_q, state_n;
    logic [CW-1:0] pcnt_q, pcnt_n;
    logic          prev_q;
    logic          rise_ev, fall_ev, ev;
    out_mode_e     mode;

    assign mode    = out_mode_e'(mode_i);
    assign rise_ev = filt_i & ~prev_q;
    assign fall_ev = ~filt_i & prev_q;

    always_comb begin
        unique case (mode)
            MODE_RISE:  ev = rise_ev;
            MODE_FALL:  ev = fall_ev;
            MODE_BOTH:  ev = rise_ev | fall_ev;
            MODE_LEVEL: ev = 1'b0;
            default:    ev = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PG_IDLE;
            pcnt_q  <= '0;
            prev_q  <= seed_i;
        end else begin
            state_q <= state_n;
            pcnt_q  <= pcnt_n;
            prev_q  <= filt_i;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        pcnt_n  = pcnt_q;
        unique case (state_q)
            PG_IDLE: begin
                pcnt_n = '0;
                if (ev) begin
                    state_n = PG_PULSE;                 // T_FIRE
                    pcnt_n  = {{(CW-1){1'b0}}, 1'b1};
                end
            end
            PG_PULSE: begin
                if (ev) begin
                    pcnt_n = {{(CW-1){1'b0}}, 1'b1};    // T_REFIRE
                end else if (pcnt_q >= thr_i) begin
                    state_n = PG_IDLE;                  // T_EXPIRE
                    pcnt_n  = '0;
                end else begin
                    pcnt_n = pcnt_q + {{(CW-1){1'b0}}, 1'b1};
                end
            end
            default: begin
                state_n = PG_IDLE;
                pcnt_n  = '0;
            end
        endcase
    end

    // Output process
    always_comb begin
        if (mode == MODE_LEVEL) pre_o = prev_q;
        else                    pre_o = (state_q == PG_PULSE);
    end

    AST_FIRE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PG_PULSE && $past(state_q) == PG_IDLE) |-> $past(ev)); // R6

    AST_LEVEL_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_LEVEL && $past(state_q) == PG_IDLE) |-> (state_q == PG_IDLE)); // R6

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (state_q == PG_PULSE) |-> (pcnt_q != '0 && 32'(pcnt_q) <= MAX_TICKS)); // R7

endmodule

// File: rtl/deglitch_edge_top.sv
module deglitch_edge_top
    import deglitch_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_in,
    input  logic [1:0] width_sel,
    input  logic [1:0] mode_sel,
    input  logic       invert,
    output logic       sig_out
);
    localparam int MAX_TICKS = 4 * TICKS_PER_UNIT;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic          sync_q;
    logic          filt;
    logic          pre;
    logic [CW-1:0] thr;
    logic          out_q;

    assign thr = CW'((32'(width_sel) + 32'd1) * 32'(TICKS_PER_UNIT));

    deglitch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .async_i (sig_in),
        .sync_o  (sync_q)
    );

    deglitch_filter #(.CW(CW), .MAX_TICKS(MAX_TICKS)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_q),
        .thr_i  (thr),
        .filt_o (filt)
    );

    deglitch_edge #(.CW(CW), .MAX_TICKS(MAX_TICKS)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .seed_i (sync_q),
        .filt_i (filt),
        .mode_i (mode_sel),
        .thr_i  (thr),
        .pre_o  (pre)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= invert;
        else     out_q <= pre ^ invert;
    end

    assign sig_out = out_q;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sig_out == $past(invert))); // R9

endmodule

// File: tb/test_deglitch_edge_top.sv
`timescale 1ns/1ps
module test_deglitch_edge_top;
    localparam int TPU = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig_in = 1'b0;
    logic [1:0] width_sel = 2'd0;
    logic [1:0] mode_sel = 2'd3;
    logic       invert = 1'b0;
    logic       sig_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    deglitch_edge_top #(.TICKS_PER_UNIT(TPU)) i_deglitch_edge_top (
        .clk       (clk),
        .rst       (rst),
        .sig_in    (sig_in),
        .width_sel (width_sel),
        .mode_sel  (mode_sel),
        .invert    (invert),
        .sig_out   (sig_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a high pulse of len ticks and measure the active output.
    task automatic run_pulse(input int sel, input int mode, input bit inv, input int len,
                             output int high, output int rises, output int first);
        int w;
        bit prev;
        bit act;
        w = (sel + 1) * TPU;
        @(negedge clk);
        width_sel = 2'(sel);
        mode_sel  = 2'(mode);
        invert    = inv;
        settle(4 * w + 12);
        high = 0; rises = 0; first = -1; prev = 1'b0;
        sig_in = 1'b1;
        for (int i = 1; i <= len + 3 * w + 12; i++) begin
            @(negedge clk);
            act = sig_out ^ inv;
            if (act) begin
                high++;
                if (first < 0) first = i;
            end
            if (act && !prev) rises++;
            prev = act;
            if (i == len) sig_in = 1'b0;
        end
    endtask

    // R2 R3 R4 R6 R7 R1: W-1 and W pulses in one mode and width
    task automatic t_glitch(input int sel, input int mode, input int len);
        int w, high, rises, first, eh, er, ef;
        w = (sel + 1) * TPU;
        run_pulse(sel, mode, 1'b0, len, high, rises, first);
        if (len < w) begin
            check(high == 0, "R3 short pulse rejected", high, 0);
        end else begin
            case (mode)
                0: begin eh = w; er = 1; ef = w + 4; end
                1: begin eh = w; er = 1; ef = len + w + 4; end
                2: begin eh = 2 * w; er = (len > w) ? 2 : 1; ef = w + 4; end
                default: begin eh = len; er = 1; ef = w + 4; end
            endcase
            check(high == eh, "R4/R7 active cycles", high, eh);
            check(rises == er, "R6 output pulse count", rises, er);
            check(first == ef, "R1/R2 output start cycle", first, ef);
        end
    endtask

    // R5: two W-1 halves split by one low tick
    task automatic t_restart();
        int high;
        bit act;
        @(negedge clk);
        width_sel = 2'd3; mode_sel = 2'd3; invert = 1'b0;
        settle(40);
        high = 0;
        sig_in = 1'b1; settle(7);
        sig_in = 1'b0; settle(1);
        sig_in = 1'b1; settle(7);
        sig_in = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            act = sig_out;
            if (act) high++;
        end
        check(high == 0, "R5 broken pulse restarts timer", high, 0);
    endtask

    // R10: shrink width mid-count
    task automatic t_width_change();
        int first;
        @(negedge clk);
        width_sel = 2'd3; mode_sel = 2'd3; invert = 1'b0;
        settle(40);
        first = -1;
        sig_in = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (sig_out && first < 0) first = i;
            if (i == 5) width_sel = 2'd0;
        end
        check(first == 8, "R10 new threshold applied mid-count", first, 8);
        sig_in = 1'b0;
        settle(20);
    endtask

    // R8 R10: inversion in level and pulse modes, acting at the next edge
    task automatic t_invert();
        int high, rises, first;
        run_pulse(0, 3, 1'b1, 2, high, rises, first);
        check(high == 2, "R8 inverted level pulse length", high, 2);
        check(sig_out == 1'b1, "R8 inverted idle level", int'(sig_out), 1);
        run_pulse(1, 0, 1'b1, 4, high, rises, first);
        check(high == 4, "R8 inverted rise pulse length", high, 4);
        @(negedge clk);
        mode_sel = 2'd3;
        invert = 1'b0;
        @(negedge clk);
        check(sig_out == 1'b0, "R10 polarity change next edge", int'(sig_out), 0);
    endtask

    // R9: reset with input high, inverted, then both-edge mode
    task automatic t_reset();
        int high;
        @(negedge clk);
        rst = 1'b1; invert = 1'b1; mode_sel = 2'd2; width_sel = 2'd0; sig_in = 1'b1;
        settle(6);
        check(sig_out == 1'b1, "R9 output inactive in reset", int'(sig_out), 1);
        rst = 1'b0;
        high = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!sig_out) high++;
        end
        check(high == 0, "R9 no edge produced by reset", high, 0);
        @(negedge clk);
        sig_in = 1'b0; invert = 1'b0;
        settle(20);
    endtask

    initial begin
        settle(6);
        check(sig_out == 1'b0, "R9 reset output level", int'(sig_out), 0);
        rst = 1'b0;
        settle(4);
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                t_glitch(s, m, (s + 1) * TPU - 1);
                t_glitch(s, m, (s + 1) * TPU);
            end
            t_glitch(s, 2, 3 * (s + 1) * TPU);
        end
        t_restart();
        t_width_change();
        t_invert();
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule